// File: doc/BRIEF.md
# Composite Sync and Blank Combiner with Equalization and Serration

This block merges the separate horizontal and vertical sync and blank components of a raster timing generator into one composite sync and one composite blank output. Inside a programmed band of vertical positions it replaces the plain composite sync waveform with narrow equalizing pulses, or with broad serrated pulses while vertical sync is active. The pulse edges come from comparing the horizontal count with programmed values, at either one or two pulses per line.

The upstream counter logic supplies the horizontal count (starting at 1), the vertical position count, the active-high component signals and the configuration values. Every output is registered, so it lags its inputs by exactly one clock. When the composite output is not selected, the sync output carries vertical sync alone and the blank output carries vertical blank alone.

A small state register records which waveform source drives composite sync in the current cycle. Its states are SEG_PLAIN (the OR of the component syncs), SEG_EQUAL (equalizing pulses) and SEG_SERRATE (serration pulses). The state is recomputed from the inputs on every clock:
- PLAIN transition: to SEG_PLAIN when insertion is off or the vertical count is outside the band.
- EQUAL transition: to SEG_EQUAL when insertion is on, the count is inside the band, and vertical sync is inactive.
- SERRATE transition: to SEG_SERRATE when insertion is on, the count is inside the band, and vertical sync is active.

Top module: `csync_combiner`

## Requirements
- R1: While `rst_n` is low, `csync_o` and `cblank_o` are 1 and `mode_err` is 0. Each output value reflects the inputs that were present at the previous rising clock edge.
- R2: When `csync_sel`=1 and insertion does not apply, the active-high composite sync is `hsync_act` OR `vsync_act`.
- R3: When `csync_sel`=1, the active-high composite blank is `hblank_act` OR `vblank_act`. When `csync_sel`=0, blank is `vblank_act` only and sync is `vsync_act` only, with no pulse insertion.
- R4: Insertion applies only when `eqser_dis`=0, `csync_sel`=1 and `int_start` <= `vcount` <= `int_end`. Both bounds are inclusive.
- R5: While insertion applies, sync follows the serration pulse when `vsync_act`=1 and the equalizing pulse when `vsync_act`=0.
- R6: The equalizing pulse is active when the phase position p satisfies `hfp_end` < p <= `eq_end`. Its width is therefore `eq_end`-`hfp_end` clocks per pulse period.
- R7: The serration pulse is active when p <= `hfp_end` or p > `ser_start`. Its width is therefore P+`hfp_end`-`ser_start` clocks, where P is the pulse period.
- R8: `mode` is encoded as 2'b00 = interlaced, double rate; 2'b01 = non-interlaced, double rate; 2'b11 = non-interlaced, single rate. At double rate, H = `htotal`>>1, P = H, and p = `hcount` when `hcount` <= H, otherwise `hcount`-H. At single rate, P = `htotal` and p = `hcount`.
- R9: `mode`=2'b10 is illegal. It behaves as 2'b11, and `mode_err` is 1 in the following cycle. For any other mode, `mode_err` is 0 in the following cycle.
- R10: `pol_sync`=1 makes `csync_o` active high; `pol_sync`=0 makes it active low. `pol_blank` sets the polarity of `cblank_o` in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hcount | input | 12 | Horizontal position, starting at 1 |
| vcount | input | 12 | Vertical position count |
| hsync_act | input | 1 | Horizontal sync component, active high |
| vsync_act | input | 1 | Vertical sync component, active high |
| hblank_act | input | 1 | Horizontal blank component, active high |
| vblank_act | input | 1 | Vertical blank component, active high |
| mode | input | 2 | Rate and interlace mode |
| eqser_dis | input | 1 | 1 disables equalization and serration insertion |
| csync_sel | input | 1 | 1 selects composite outputs |
| pol_sync | input | 1 | Sync output polarity, 1 = active high |
| pol_blank | input | 1 | Blank output polarity, 1 = active high |
| hfp_end | input | 12 | Horizontal front porch end count |
| htotal | input | 12 | Clocks per line (even) |
| eq_end | input | 12 | Equalizing pulse end count |
| ser_start | input | 12 | Serration gap end count |
| int_start | input | 12 | First vertical position of the insertion band |
| int_end | input | 12 | Last vertical position of the insertion band |
| csync_o | output | 1 | Composite or vertical sync |
| cblank_o | output | 1 | Composite or vertical blank |
| mode_err | output | 1 | Illegal mode flag |

## Verification
A wrong state would select the wrong waveform source. That shows on `csync_o` one clock later: a line at the band edge would carry plain sync instead of pulses, or the reverse. Errors in the phase fold or the comparisons change the number of active clocks per line. Every line swept through the pulse region therefore exposes them within one line. Random configurations cover the band bounds, the polarities and all four mode codes, and each cycle is compared with an expected value derived from the requirements.

// File: rtl/csync_pkg.sv
package csync_pkg;
    typedef enum logic [1:0] {
        SEG_PLAIN   = 2'd0,
        SEG_EQUAL   = 2'd1,
        SEG_SERRATE = 2'd2
    } seg_t;

    localparam logic [1:0] MODE_ILLEGAL = 2'b10;
    localparam logic [1:0] MODE_SINGLE  = 2'b11;
endpackage

// File: rtl/csync_phase.sv
module csync_phase #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hcount,
    input  logic [W-1:0] htotal,
    input  logic [W-1:0] hfp_end,
    input  logic [W-1:0] eq_end,
    input  logic [W-1:0] ser_start,
    input  logic         double_rate,
    output logic         eq_pulse,
    output logic         ser_pulse
);
    logic [W-1:0] half_pt;
    logic [W-1:0] pos;

    // half-line point: line total shifted right by one
    assign half_pt = htotal >> 1;

    always_comb begin
        if (double_rate && (hcount > half_pt)) begin
            pos = hcount - half_pt;
        end else begin
            pos = hcount;
        end
    end

    assign eq_pulse  = (pos > hfp_end) && (pos <= eq_end);
    assign ser_pulse = (pos <= hfp_end) || (pos > ser_start);

    // R8: the folded position never passes the half-line point
    assert_fold_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (double_rate && !htotal[0] && (hcount <= htotal)) |-> (pos <= half_pt));
endmodule

// File: rtl/csync_region.sv
module csync_region
    import csync_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [W-1:0] vcount,
    input  logic [W-1:0] int_start,
    input  logic [W-1:0] int_end,
    input  logic         vsync_act,
    input  logic         ins_en,
    output seg_t         seg_next
);
    logic in_band;

    assign in_band = (vcount >= int_start) && (vcount <= int_end);

    always_comb begin
        unique case ({ins_en && in_band, vsync_act})
            2'b10:   seg_next = SEG_EQUAL;
            2'b11:   seg_next = SEG_SERRATE;
            default: seg_next = SEG_PLAIN;
        endcase
    end
endmodule

// File: rtl/csync_combiner.sv
module csync_combiner
    import csync_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hcount,
    input  logic [W-1:0] vcount,
    input  logic         hsync_act,
    input  logic         vsync_act,
    input  logic         hblank_act,
    input  logic         vblank_act,
    input  logic [1:0]   mode,
    input  logic         eqser_dis,
    input  logic         csync_sel,
    input  logic         pol_sync,
    input  logic         pol_blank,
    input  logic [W-1:0] hfp_end,
    input  logic [W-1:0] htotal,
    input  logic [W-1:0] eq_end,
    input  logic [W-1:0] ser_start,
    input  logic [W-1:0] int_start,
    input  logic [W-1:0] int_end,
    output logic         csync_o,
    output logic         cblank_o,
    output logic         mode_err
);
    logic double_rate;
    logic ins_en;
    logic eq_pulse;
    logic ser_pulse;
    seg_t seg_next;
    seg_t seg_q;
    logic eq_q, ser_q, hs_q, vs_q, hb_q, vb_q, sel_q, psync_q, pblank_q;
    logic sync_act;
    logic blank_act;

    // illegal code falls back to single rate
    assign double_rate = (mode != MODE_SINGLE) && (mode != MODE_ILLEGAL);
    assign ins_en      = !eqser_dis && csync_sel;

    csync_phase #(.W(W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .hcount      (hcount),
        .htotal      (htotal),
        .hfp_end     (hfp_end),
        .eq_end      (eq_end),
        .ser_start   (ser_start),
        .double_rate (double_rate),
        .eq_pulse    (eq_pulse),
        .ser_pulse   (ser_pulse)
    );

    csync_region #(.W(W)) u_region (
        .vcount    (vcount),
        .int_start (int_start),
        .int_end   (int_end),
        .vsync_act (vsync_act),
        .ins_en    (ins_en),
        .seg_next  (seg_next)
    );

    // state register and aligned component flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q    <= SEG_PLAIN;
            eq_q     <= 1'b0;
            ser_q    <= 1'b0;
            hs_q     <= 1'b0;
            vs_q     <= 1'b0;
            hb_q     <= 1'b0;
            vb_q     <= 1'b0;
            sel_q    <= 1'b0;
            psync_q  <= 1'b0;
            pblank_q <= 1'b0;
            mode_err <= 1'b0;
        end else begin
            seg_q    <= seg_next;
            eq_q     <= eq_pulse;
            ser_q    <= ser_pulse;
            hs_q     <= hsync_act;
            vs_q     <= vsync_act;
            hb_q     <= hblank_act;
            vb_q     <= vblank_act;
            sel_q    <= csync_sel;
            psync_q  <= pol_sync;
            pblank_q <= pol_blank;
            mode_err <= (mode == MODE_ILLEGAL);
        end
    end

    // output decode by state
    always_comb begin
        unique case (seg_q)
            SEG_PLAIN:   sync_act = sel_q ? (hs_q || vs_q) : vs_q;
            SEG_EQUAL:   sync_act = eq_q;
            SEG_SERRATE: sync_act = ser_q;
            default:     sync_act = 1'b0;
        endcase
        blank_act = sel_q ? (hb_q || vb_q) : vb_q;
        csync_o   = sync_act ~^ psync_q;
        cblank_o  = blank_act ~^ pblank_q;
    end

    assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ILLEGAL) |=> mode_err);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_ILLEGAL) |=> !mode_err);

    assert_plain_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eqser_dis || !csync_sel) |=> (seg_q == SEG_PLAIN));

    assert_unsel_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !csync_sel |=> (csync_o == ($past(vsync_act) ~^ $past(pol_sync))));

    assert_comp_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        csync_sel |=> (cblank_o == (($past(hblank_act) || $past(vblank_act)) ~^ $past(pol_blank))));
endmodule

// File: tb/csync_combiner_bench.sv
module csync_combiner_bench;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] hcount = '0, vcount = '0;
    logic hsync_act = 0, vsync_act = 0, hblank_act = 0, vblank_act = 0;
    logic [1:0] mode = 2'b00;
    logic eqser_dis = 0, csync_sel = 0, pol_sync = 0, pol_blank = 0;
    logic [W-1:0] hfp_end = '0, htotal = '0, eq_end = '0, ser_start = '0;
    logic [W-1:0] int_start = '0, int_end = '0;
    logic csync_o, cblank_o, mode_err;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    csync_combiner #(.W(W)) u_csync_combiner (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .hsync_act(hsync_act), .vsync_act(vsync_act),
        .hblank_act(hblank_act), .vblank_act(vblank_act),
        .mode(mode), .eqser_dis(eqser_dis), .csync_sel(csync_sel),
        .pol_sync(pol_sync), .pol_blank(pol_blank),
        .hfp_end(hfp_end), .htotal(htotal), .eq_end(eq_end),
        .ser_start(ser_start), .int_start(int_start), .int_end(int_end),
        .csync_o(csync_o), .cblank_o(cblank_o), .mode_err(mode_err)
    );

    function automatic logic ref_sync();
        int half, p;
        logic dbl, act;
        half = int'(htotal) / 2;
        dbl  = (mode == 2'b00) || (mode == 2'b01);
        p    = (dbl && int'(hcount) > half) ? int'(hcount) - half : int'(hcount);
        if (!csync_sel) act = vsync_act;
        else if (!eqser_dis && vcount >= int_start && vcount <= int_end)
            act = vsync_act ? (p <= int'(hfp_end) || p > int'(ser_start))
                            : (p > int'(hfp_end) && p <= int'(eq_end));
        else act = hsync_act || vsync_act;
        return pol_sync ? act : !act;
    endfunction

    function automatic logic ref_blank();
        logic act;
        act = csync_sel ? (hblank_act || vblank_act) : vblank_act;
        return pol_blank ? act : !act;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // count active sync clocks over one swept line
    task automatic sweep_line(output int cnt);
        cnt = 0;
        for (int h = 1; h <= int'(htotal); h++) begin
            hcount = W'(h);
            @(posedge clk); #1;
            if (csync_o == pol_sync) cnt++;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic es, eb;
        void'($urandom(32'd20240));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 reset csync", csync_o, 1);
        chk("R1 reset cblank", cblank_o, 1);
        chk("R1 reset mode_err", mode_err, 0);
        rst_n = 1;

        htotal = 40; hfp_end = 3; eq_end = 6; ser_start = 15;
        int_start = 5; int_end = 10; csync_sel = 1; eqser_dis = 0;
        pol_sync = 1; pol_blank = 1;

        mode = 2'b00; vcount = 6; vsync_act = 0;
        sweep_line(cnt); chk("R6 R8 eq double width", cnt, 6);
        mode = 2'b11;
        sweep_line(cnt); chk("R6 R8 eq single width", cnt, 3);
        mode = 2'b10;
        sweep_line(cnt); chk("R9 illegal as single", cnt, 3);
        chk("R9 mode_err set", mode_err, 1);
        mode = 2'b01; vsync_act = 1;
        sweep_line(cnt); chk("R5 R7 serration double width", cnt, 16);
        chk("R9 mode_err clear", mode_err, 0);
        mode = 2'b11;
        sweep_line(cnt); chk("R7 serration single width", cnt, 28);
        mode = 2'b00; vsync_act = 0;
        vcount = 10; sweep_line(cnt); chk("R4 band end inclusive", cnt, 6);
        vcount = 5;  sweep_line(cnt); chk("R4 band start inclusive", cnt, 6);
        vcount = 4;  sweep_line(cnt); chk("R4 R2 below band plain", cnt, 0);
        vcount = 11; hsync_act = 1; sweep_line(cnt); chk("R2 above band hsync", cnt, 40);
        hsync_act = 0; vcount = 6; vsync_act = 1; eqser_dis = 1;
        sweep_line(cnt); chk("R4 disabled plain vsync", cnt, 40);
        eqser_dis = 0; csync_sel = 0; vsync_act = 0; hsync_act = 1;
        sweep_line(cnt); chk("R3 unselected vsync only", cnt, 0);
        csync_sel = 1; hsync_act = 0; pol_sync = 0;
        sweep_line(cnt); chk("R10 active low eq width", cnt, 6);
        pol_blank = 0; hblank_act = 1; vblank_act = 0;
        @(posedge clk); #1; chk("R10 R3 blank active low", cblank_o, 0);
        csync_sel = 0;
        @(posedge clk); #1; chk("R3 unselected blank ignores hblank", cblank_o, 1);

        for (int i = 0; i < 4000; i++) begin
            htotal    = W'(2 * (10 + $urandom_range(0, 90)));
            hfp_end   = W'($urandom_range(0, 12));
            eq_end    = W'($urandom_range(0, 30));
            ser_start = W'($urandom_range(0, 60));
            int_start = W'($urandom_range(0, 20));
            int_end   = W'($urandom_range(0, 30));
            vcount    = W'($urandom_range(0, 32));
            hcount    = W'($urandom_range(1, int'(htotal)));
            mode      = 2'($urandom_range(0, 3));
            {hsync_act, vsync_act, hblank_act, vblank_act} = 4'($urandom());
            eqser_dis = ($urandom_range(0, 3) == 0);
            csync_sel = ($urandom_range(0, 4) != 0);
            pol_sync  = 1'($urandom());
            pol_blank = 1'($urandom());
            es = ref_sync();
            eb = ref_blank();
            @(posedge clk); #1;
            if (i % 4 == 0) chk("R2 R4 R5 R6 R7 R8 R10 random sync", csync_o, es);
            if (i % 16 == 1) chk("R3 R10 random blank", cblank_o, eb);
            if (i % 64 == 2) chk("R9 random mode_err", mode_err, int'(mode == 2'b10));
            if (csync_o != es && i % 4 != 0) chk("R5 random sync extra", csync_o, es);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule